// File: doc/BRIEF.md
# Four-Level FSK Modem Control and Symbol Status Core

This block is the digital control and status core of a four-level FSK modem. A host programs an 8-bit mode register over a simple synchronous bus and reads a status register that holds an interrupt flag, a symbol-ready flag, the last received two-bit symbol and a settled indication. In transmit mode the block supplies the next two-bit symbol, taken from the mode register at each symbol-rate strobe. In receive mode it captures the symbols that the demodulator delivers.

The block also drives the power-save enables for the filters, the symbol extraction circuit and the transmit buffer. It drives the select that routes the equalised receive signal to the transmit output for eye monitoring. After power-save is left, it counts a programmable number of symbol strobes before it declares the filters settled and the transmit output valid. The analog paths, the clock recovery and the demodulator are outside the block; they appear only as strobes, symbol inputs and enables.

Top module: `modem_ctrl_core`

## Requirements
- R1: On a synchronous active-low reset, the mode register (address 0) reads 0x00 and the status register (address 1) reads 0x00. Reset restarts the settling count as though power-save had just been left.
- R2: A bus write to address 0 stores the mode register. Its fields are: bits [1:0] the transmit symbol select, bit 2 the symbol interrupt enable, bit 3 power-save, bit 4 the eye monitor, and bit 5 the direction (1 = transmit, 0 = receive). Bits [7:6] always read 0.
- R3: In receive mode, outside power-save, a cycle with `rx_sym_valid` high sets status bit 1 (symbol ready) and loads status bits [3:2] with `rx_sym` at the next edge. If the interrupt enable is 1, the same event sets status bit 0 (IRQ).
- R4: In transmit mode, outside power-save, each `sym_strobe` loads `tx_sym` from mode bits [1:0] and sets symbol ready, plus IRQ when the interrupt enable is 1. A write to the select bits between strobes leaves `tx_sym` unchanged until the next strobe.
- R5: When the interrupt enable is 0, symbol events still set symbol ready and update the received-symbol field, but IRQ keeps its value.
- R6: A bus read of address 1 returns the status value from before the read, then clears IRQ and symbol ready at that edge. A symbol event in the same cycle takes priority and leaves them set.
- R7: While power-save is 1, `filt_en`, `symx_en` and `txbuf_en` are low, and symbol strobes and received symbols are ignored. The bus stays fully usable.
- R8: Status bit 4 (settled) is 0 during power-save. It rises at the edge of the SETTLE_SYMS-th `sym_strobe` after power-save is left (20 by default). `tx_valid` is high only in transmit mode with settled at 1.
- R9: `eye_sel` is high only when the eye-monitor bit is 1 and the modem is in receive mode.
- R10: In receive mode, the select bits and `sym_strobe` have no effect on `tx_sym` or the status flags. In transmit mode, `rx_sym_valid` has no effect on the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_addr | input | 1 | Register address (0 mode, 1 status) |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| sym_strobe | input | 1 | One-cycle pulse per symbol period |
| rx_sym_valid | input | 1 | Demodulator delivers a symbol this cycle |
| rx_sym | input | 2 | Received symbol value |
| tx_sym | output | 2 | Symbol currently being transmitted |
| tx_valid | output | 1 | Transmit output is settled and usable |
| filt_en | output | 1 | Filter power enable |
| symx_en | output | 1 | Symbol/clock extraction power enable |
| txbuf_en | output | 1 | Transmit output buffer enable |
| eye_sel | output | 1 | Route equalised receive signal to transmit output |

## Verification
The bench builds the core with the default SETTLE_SYMS of 20, so the settle window is walked in full. The bench checks the output one strobe before the end of the window and again on the final strobe, both after reset and after a power-save exit. Because the counter width is derived from this value, the run also covers the final count of the terminal compare. The default 8-bit register layout lets every field be written and read back, including the case where a read and a received symbol land in the same cycle.

// File: rtl/modem_ctrl_pkg.sv
// Package: shared register layouts and addresses for the modem control core.
// Assumes an 8-bit host bus and a 1-bit register address.
package modem_ctrl_pkg;

    localparam int REG_W   = 8;
    localparam int ADDR_W  = 1;
    localparam int SYM_W   = 2;

    localparam logic [ADDR_W-1:0] ADDR_MODE   = 1'b0;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 1'b1;

    // Mode register, msb first: reserved, direction, eye, powersave, irq enable, select.
    typedef struct packed {
        logic [1:0]       rsvd;
        logic             tx_mode;
        logic             eye_mon;
        logic             psave;
        logic             sym_irq_en;
        logic [SYM_W-1:0] tx_sel;
    } mode_t;

    // Status register, msb first: reserved, settled, received symbol, ready, irq.
    typedef struct packed {
        logic [2:0]       rsvd;
        logic             settled;
        logic [SYM_W-1:0] rx_sym;
        logic             sym_rdy;
        logic             irq;
    } status_t;

endpackage

// File: rtl/mode_regs.sv
// Module: mode_regs
// Holds the host-writable mode register. Reserved bits are forced to zero.
// Assumes the write strobe is a single cycle and the address is stable with it.
module mode_regs
    import modem_ctrl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    output mode_t             mode
);

    mode_t wr_val;

    // Shape incoming data into the mode layout with reserved bits cleared.
    always_comb begin
        wr_val      = mode_t'(wdata);
        wr_val.rsvd = '0;
    end

    // Store the mode register on an addressed write; reset clears every field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= '0;
        end else if (wr_en && (addr == ADDR_MODE)) begin
            mode <= wr_val;
        end
    end

endmodule

// File: rtl/settle_timer.sv
// Module: settle_timer
// Counts symbol strobes after leaving power-save, then reports settled.
// Assumes sym_strobe is a one-cycle pulse per symbol. Reset behaves like
// a power-save exit, so a fresh count starts after reset.
module settle_timer #(
    parameter int SETTLE_SYMS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic psave,
    input  logic sym_strobe,
    output logic settled
);

    localparam int CNT_W = (SETTLE_SYMS > 1) ? $clog2(SETTLE_SYMS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_SYMS - 1);

    logic [CNT_W-1:0] cnt;

    // Hold the count at zero during power-save; advance on each strobe until the last one.
    always_ff @(posedge clk) begin
        if (!rst_n || psave) begin
            cnt     <= '0;
            settled <= 1'b0;
        end else if (!settled && sym_strobe) begin
            if (cnt == LAST) begin
                settled <= 1'b1;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/sym_status.sv
// Module: sym_status
// Turns direction-dependent symbol events into status flags and keeps the
// transmit symbol register. Assumes the caller decodes the status read.
// An event and a read in the same cycle: the event wins.
module sym_status
    import modem_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  mode_t            mode,
    input  logic             sym_strobe,
    input  logic             rx_valid,
    input  logic [SYM_W-1:0] rx_sym_in,
    input  logic             rd_status,
    output logic             irq,
    output logic             sym_rdy,
    output logic [SYM_W-1:0] rx_field,
    output logic [SYM_W-1:0] tx_sym
);

    logic ev_tx;
    logic ev_rx;
    logic ev_any;

    // Qualify events by direction; power-save silences both.
    always_comb begin
        ev_tx  = sym_strobe &  mode.tx_mode & ~mode.psave;
        ev_rx  = rx_valid   & ~mode.tx_mode & ~mode.psave;
        ev_any = ev_tx | ev_rx;
    end

    // IRQ: set on an enabled event, else cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (ev_any && mode.sym_irq_en) begin
            irq <= 1'b1;
        end else if (rd_status) begin
            irq <= 1'b0;
        end
    end

    // Symbol ready: set on any event, else cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_rdy <= 1'b0;
        end else if (ev_any) begin
            sym_rdy <= 1'b1;
        end else if (rd_status) begin
            sym_rdy <= 1'b0;
        end
    end

    // Capture the received symbol value on a receive event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_field <= '0;
        end else if (ev_rx) begin
            rx_field <= rx_sym_in;
        end
    end

    // Sample the transmit select at each transmit symbol boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sym <= '0;
        end else if (ev_tx) begin
            tx_sym <= mode.tx_sel;
        end
    end

endmodule

// File: rtl/modem_ctrl_core.sv
// Module: modem_ctrl_core (top)
// Control and status core of a four-level FSK modem: mode register, symbol
// status, power-save enables, eye-monitor select and settle tracking.
// Assumes a single clock and a synchronous active-low reset. Read data is
// combinational from the addressed register.
module modem_ctrl_core
    import modem_ctrl_pkg::*;
#(
    parameter int SETTLE_SYMS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [REG_W-1:0]  bus_wdata,
    output logic [REG_W-1:0]  bus_rdata,
    input  logic              sym_strobe,
    input  logic              rx_sym_valid,
    input  logic [SYM_W-1:0]  rx_sym,
    output logic [SYM_W-1:0]  tx_sym,
    output logic              tx_valid,
    output logic              filt_en,
    output logic              symx_en,
    output logic              txbuf_en,
    output logic              eye_sel
);

    mode_t            mode;
    status_t          status;
    logic             rd_status;
    logic             settled;
    logic             irq;
    logic             sym_rdy;
    logic [SYM_W-1:0] rx_field;

    mode_regs u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .mode  (mode)
    );

    settle_timer #(.SETTLE_SYMS(SETTLE_SYMS)) u_settle (
        .clk        (clk),
        .rst_n      (rst_n),
        .psave      (mode.psave),
        .sym_strobe (sym_strobe),
        .settled    (settled)
    );

    sym_status u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .sym_strobe (sym_strobe),
        .rx_valid   (rx_sym_valid),
        .rx_sym_in  (rx_sym),
        .rd_status  (rd_status),
        .irq        (irq),
        .sym_rdy    (sym_rdy),
        .rx_field   (rx_field),
        .tx_sym     (tx_sym)
    );

    // Decode the status read and assemble the status word.
    always_comb begin
        rd_status      = bus_rd && (bus_addr == ADDR_STATUS);
        status         = '0;
        status.settled = settled;
        status.rx_sym  = rx_field;
        status.sym_rdy = sym_rdy;
        status.irq     = irq;
    end

    // Select read data from the addressed register.
    always_comb begin
        bus_rdata = (bus_addr == ADDR_STATUS) ? REG_W'(status) : REG_W'(mode);
    end

    // Power enables, eye routing and transmit validity.
    always_comb begin
        filt_en  = ~mode.psave;
        symx_en  = ~mode.psave;
        txbuf_en = ~mode.psave;
        eye_sel  = mode.eye_mon & ~mode.tx_mode;
        tx_valid = mode.tx_mode & settled & ~mode.psave;
    end

endmodule

// File: rtl/modem_ctrl_checker.sv
// Module: modem_ctrl_checker
// Property checks for modem_ctrl_core, attached with bind.
module modem_ctrl_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       psave,
    input logic       tx_mode,
    input logic       irq_en,
    input logic       rd_status,
    input logic       sym_strobe,
    input logic       rx_sym_valid,
    input logic [1:0] rx_sym,
    input logic [7:0] status_word,
    input logic       filt_en,
    input logic       symx_en,
    input logic       txbuf_en,
    input logic       eye_sel,
    input logic       tx_valid
);

    logic ev;
    assign ev = ((sym_strobe && tx_mode) || (rx_sym_valid && !tx_mode)) && !psave;

    // R7: power-save turns every analog enable off
    a_r7_enables_off: assert property (@(posedge clk) disable iff (!rst_n)
        psave |-> (!filt_en && !symx_en && !txbuf_en));

    // R9: eye routing never active in transmit mode
    a_r9_eye_rx_only: assert property (@(posedge clk) disable iff (!rst_n)
        eye_sel |-> !tx_mode);

    // R8: power-save forces settled low at the next edge
    a_r8_psave_unsettles: assert property (@(posedge clk) disable iff (!rst_n)
        psave |=> !status_word[4]);

    // R8: transmit valid needs settled and transmit mode
    a_r8_tx_valid_gate: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (status_word[4] && tx_mode));

    // R3: receive event captures the symbol and sets ready
    a_r3_rx_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_sym_valid && !tx_mode && !psave) |=>
            (status_word[3:2] == $past(rx_sym) && status_word[1]));

    // R6: a read without an event clears irq and ready
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_status && !ev) |=> (!status_word[0] && !status_word[1]));

    // R5: with interrupts disabled an event leaves irq untouched
    a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && !irq_en && !rd_status) |=> (status_word[0] == $past(status_word[0])));

endmodule

bind modem_ctrl_core modem_ctrl_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .psave        (mode.psave),
    .tx_mode      (mode.tx_mode),
    .irq_en       (mode.sym_irq_en),
    .rd_status    (rd_status),
    .sym_strobe   (sym_strobe),
    .rx_sym_valid (rx_sym_valid),
    .rx_sym       (rx_sym),
    .status_word  (status),
    .filt_en      (filt_en),
    .symx_en      (symx_en),
    .txbuf_en     (txbuf_en),
    .eye_sel      (eye_sel),
    .tx_valid     (tx_valid)
);

// File: tb/tb_modem_ctrl_core.sv
// Directed bench for modem_ctrl_core: one task per scenario.
module tb_modem_ctrl_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sym_strobe = 1'b0;
    logic       rx_sym_valid = 1'b0;
    logic [1:0] rx_sym = '0;
    logic [1:0] tx_sym;
    logic       tx_valid, filt_en, symx_en, txbuf_en, eye_sel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    modem_ctrl_core #(.SETTLE_SYMS(20)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sym_strobe(sym_strobe), .rx_sym_valid(rx_sym_valid), .rx_sym(rx_sym),
        .tx_sym(tx_sym), .tx_valid(tx_valid), .filt_en(filt_en),
        .symx_en(symx_en), .txbuf_en(txbuf_en), .eye_sel(eye_sel)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic strobe();
        @(negedge clk);
        sym_strobe = 1'b1;
        @(negedge clk);
        sym_strobe = 1'b0;
    endtask

    task automatic rx_event(input logic [1:0] s);
        @(negedge clk);
        rx_sym_valid = 1'b1; rx_sym = s;
        @(negedge clk);
        rx_sym_valid = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        bus_read(1'b0, d);  check("R1 mode after reset", d, 8'h00);
        bus_read(1'b1, d);  check("R1 status after reset", d, 8'h00);
        check("R1 filt_en after reset", filt_en, 1);
        check("R1 tx_valid after reset", tx_valid, 0);
    endtask

    task automatic t_settle_after_reset();
        logic [7:0] d;
        for (int i = 0; i < 19; i++) strobe();
        bus_read(1'b1, d);  check("R8 not settled after 19 strobes", d[4], 0);
        strobe();
        bus_read(1'b1, d);  check("R8 settled after 20 strobes", d[4], 1);
    endtask

    task automatic t_rx();
        logic [7:0] d;
        bus_write(1'b0, 8'hC4);
        bus_read(1'b0, d);  check("R2 reserved bits read zero", d, 8'h04);
        rx_event(2'd2);
        bus_read(1'b1, d);  check("R3 rx event status", d, 8'h1B);
        bus_read(1'b1, d);  check("R6 read clears flags", d, 8'h18);
    endtask

    task automatic t_irq_off();
        logic [7:0] d;
        bus_write(1'b0, 8'h00);
        rx_event(2'd3);
        bus_read(1'b1, d);  check("R5 ready set irq unchanged", d, 8'h1E);
    endtask

    task automatic t_read_collision();
        logic [7:0] d;
        bus_write(1'b0, 8'h04);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 1'b1; rx_sym_valid = 1'b1; rx_sym = 2'd1;
        #1 d = bus_rdata;
        check("R6 read returns pre-event value", d, 8'h1C);
        @(negedge clk);
        bus_rd = 1'b0; rx_sym_valid = 1'b0;
        bus_read(1'b1, d);  check("R6 event wins over clear", d, 8'h17);
    endtask

    task automatic t_tx();
        logic [7:0] d;
        bus_write(1'b0, 8'h25);
        strobe();
        check("R4 tx symbol loaded", tx_sym, 1);
        check("R8 tx_valid when settled", tx_valid, 1);
        bus_read(1'b1, d);  check("R4 tx event flags", d & 8'h13, 8'h13);
        bus_write(1'b0, 8'h27);
        check("R4 select waits for strobe", tx_sym, 1);
        strobe();
        check("R4 new select at strobe", tx_sym, 3);
        bus_read(1'b1, d);
        rx_event(2'd2);
        bus_read(1'b1, d);  check("R10 rx ignored in tx mode", d, 8'h14);
    endtask

    task automatic t_rx_ignores_select();
        logic [7:0] d;
        bus_write(1'b0, 8'h04);
        bus_read(1'b1, d);
        strobe();
        check("R10 tx_sym unchanged in rx mode", tx_sym, 3);
        bus_read(1'b1, d);  check("R10 strobe no flags in rx mode", d & 8'h03, 0);
    endtask

    task automatic t_eye();
        bus_write(1'b0, 8'h10);
        check("R9 eye in rx mode", eye_sel, 1);
        bus_write(1'b0, 8'h30);
        check("R9 eye blocked in tx mode", eye_sel, 0);
    endtask

    task automatic t_psave();
        logic [7:0] d;
        bus_write(1'b0, 8'h2C);
        check("R7 filt_en off", filt_en, 0);
        check("R7 symx_en off", symx_en, 0);
        check("R7 txbuf_en off", txbuf_en, 0);
        check("R8 tx_valid off in psave", tx_valid, 0);
        bus_read(1'b1, d);
        strobe();
        check("R7 tx_sym frozen in psave", tx_sym, 3);
        bus_read(1'b1, d);  check("R7 no flags in psave", d & 8'h13, 0);
        bus_write(1'b0, 8'h20);
        check("R7 enables back on", filt_en, 1);
        for (int i = 0; i < 19; i++) strobe();
        check("R8 tx_valid low before window end", tx_valid, 0);
        strobe();
        check("R8 tx_valid after 20 strobes", tx_valid, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_settle_after_reset();
        t_rx();
        t_irq_off();
        t_read_collision();
        t_tx();
        t_rx_ignores_select();
        t_eye();
        t_psave();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule